// File: doc/BRIEF.md
# Nested Interrupt Level Controller

This block is a small interrupt-control unit with two parts. The top-level path produces the highest-priority request. Its source is either a watchdog end-of-count pulse or an external non-maskable pin. The pin is synchronised and edge-detected, and software chooses which edge triggers it. A detected event sets a pending flag. That flag stays set until the service acknowledge clears it. A sticky non-maskable flag lets the pending flag raise the request even when the enables are off. Software can set this flag, but only a reset clears it. The same control register also routes the watchdog or the external interrupt pin to interrupt channel A0. The watchdog can never drive both destinations at once.

The second part is a nested-mode hold tracker, a 7-bit set of preempted priority levels. A level is marked when a routine running at it is interrupted by a higher-priority request that is not the top-level request. On interrupt return, the highest-priority marked level (the lowest number) is reported as the level being resumed, and its mark is cleared.

Software reaches two byte-wide registers through one address bit. Address 0 is the control register: vector high nibble in bits 7:4, trigger edge in bit 3, top-level source in bit 2, A0 source in bit 1, wait enable in bit 0. Address 1 is the nesting register: the sticky flag in bit 7 and the hold levels in bits 6:0. Register reads are combinational. Register writes take effect on the clock edge.

Top module: `nested_level_ctrl`

## Requirements
- R1: After reset the nesting register (address 1) reads 0x00. The low nibble of the control register (address 0) reads 0110b, which selects the falling edge, the pin as top-level source, and the external pin for A0, with wait disabled. tl_pending and tl_req are 0.
- R2: When the pin is the top-level source (control bit 2 = 1), the trigger edge is chosen by control bit 3 (0 = falling, 1 = rising). A change of nmi_pin sets tl_pending on the third rising clock edge after the change. The opposite edge never sets it.
- R3: When the watchdog is the top-level source (control bit 2 = 0), a one-cycle wdog_eoc pulse sets tl_pending at the next edge, and pin edges are ignored. When bit 2 = 1, wdog_eoc has no effect on tl_pending.
- R4: The A0 source inta0_src follows ext_int_pin when control bit 1 = 1. When bit 1 = 0 and bit 2 = 1, it follows wdog_eoc. When bit 2 = 0, it follows ext_int_pin whatever bit 1 holds.
- R5: Writing 1 to nesting bit 7 sets the sticky non-maskable flag. A later write of 0 leaves it at 1. Only reset clears it.
- R6: While the sticky flag is 0, tl_req is 1 only when int_en, tl_mask and tl_pending are all 1.
- R7: While the sticky flag is 1, tl_req equals tl_pending whatever int_en and tl_mask are.
- R8: tl_ack clears tl_pending at the next edge. If a top-level event arrives in the same cycle as tl_ack, the pending flag stays set.
- R9: Hold bit cur_level is set when nested_mode, preempt_vld and new_level < cur_level are all true and new_top = 0. The bit is not set by a top-level preemption, by a lower-priority request, or outside nested mode.
- R10: resume_vld is 1 when any hold bit is set, and resume_level gives the lowest-numbered set bit. An iret pulse clears that bit.
- R11: Hold bits cannot be written by software. A write to the nesting register changes only bit 7, and bits 6:0 read back the hold levels.
- R12: When iret and a qualifying preemption fall in the same cycle, the bit cleared is the lowest set bit as it was before that edge, and the new bit is set as well.
- R13: All eight control-register bits read back the last value written, and vec_hi and ext_wait_en reflect bits 7:4 and bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 nesting |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| nmi_pin | input | 1 | Asynchronous non-maskable pin |
| wdog_eoc | input | 1 | Watchdog end-of-count pulse |
| ext_int_pin | input | 1 | External interrupt pin for channel A0 |
| int_en | input | 1 | Global interrupt enable |
| tl_mask | input | 1 | Top-level mask bit (1 = allowed) |
| tl_ack | input | 1 | Top-level service acknowledge |
| tl_req | output | 1 | Top-level request |
| tl_pending | output | 1 | Top-level pending flag |
| inta0_src | output | 1 | Routed source of channel A0 |
| vec_hi | output | 4 | External vector high nibble |
| ext_wait_en | output | 1 | Wait-stretch enable bit |
| nested_mode | input | 1 | Nested mode active |
| preempt_vld | input | 1 | A request is being accepted over the running routine |
| cur_level | input | 3 | Level of the running routine |
| new_level | input | 3 | Level of the accepted request |
| new_top | input | 1 | The accepted request is the top-level one |
| iret | input | 1 | Interrupt-return strobe |
| hold_levels | output | 7 | Preempted-level set |
| resume_vld | output | 1 | Some level is waiting to resume |
| resume_level | output | 3 | Level that the next return resumes |

## Verification
Two events can fall in the same cycle, and each has a defined outcome. The first is a top-level event arriving together with the service acknowledge: a watchdog pulse is driven in the same cycle as tl_ack, and the bench expects tl_pending to stay 1. A later acknowledge on its own must then clear it. The second is an interrupt return arriving together with a qualifying preemption: with levels 5 and 2 held, the bench first returns once so that only 5 remains, then drives iret together with a level-3 preemption. It expects only bit 3 set afterwards, which shows that the clear used the set as it stood before the edge and that the new mark was kept.

// File: rtl/nlc_pkg.sv
// Package: shared constants for the nested interrupt level controller.
// Assumes an 8-bit register port and seven nestable levels (level 0 highest).
package nlc_pkg;
    localparam int DATA_W  = 8;
    localparam int LEVELS  = 7;
    localparam int LVL_W   = $clog2(LEVELS + 1);

    // register select on the one-bit address
    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_NEST = 1'b1
    } reg_sel_e;

    // control register bit positions (the vector nibble is decoded upstream)
    localparam int CB_WAIT  = 0;
    localparam int CB_A0PIN = 1;
    localparam int CB_TLPIN = 2;
    localparam int CB_RISE  = 3;
    localparam int CB_VLO   = 4;

    // nesting register: sticky flag at the top bit
    localparam int NB_STICKY = DATA_W - 1;

    // control register value after reset (low nibble only)
    localparam logic [3:0] CTRL_RST_LO = 4'b0110;
endpackage

// File: rtl/nlc_ctrl_regs.sv
// Module: nlc_ctrl_regs
// Holds the control register and the sticky non-maskable flag, and muxes read data.
// Assumes DATA_W = LEVELS + 1 so the nesting register packs flag and hold bits.
// The vector nibble is intentionally not reset.
module nlc_ctrl_regs
    import nlc_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int LVS = LEVELS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           addr,
    input  logic [W-1:0]   wdata,
    input  logic [LVS-1:0] hold,
    output logic [W-1:0]   rdata,
    output logic [3:0]     vec_hi,
    output logic           edge_rise,
    output logic           tl_from_pin,
    output logic           a0_from_pin,
    output logic           wait_en,
    output logic           nm_flag
);
    localparam int VHI_W = W - CB_VLO;

    logic [VHI_W-1:0] vhi_q;
    logic [3:0]       lo_q;
    logic             nm_q;
    reg_sel_e         sel;

    assign sel = reg_sel_e'(addr);

    // vector nibble: loaded by software only, no reset value
    always_ff @(posedge clk) begin
        if (wr_en && sel == SEL_CTRL) begin
            vhi_q <= wdata[W-1:CB_VLO];
        end
    end

    // control low nibble: reset to defaults, written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= CTRL_RST_LO;
        end else if (wr_en && sel == SEL_CTRL) begin
            lo_q <= wdata[CB_VLO-1:0];
        end
    end

    // sticky flag: writes can set it, only reset clears it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nm_q <= 1'b0;
        end else if (wr_en && sel == SEL_NEST && wdata[NB_STICKY]) begin
            nm_q <= 1'b1;
        end
    end

    // read mux over the two registers
    always_comb begin
        unique case (sel)
            SEL_CTRL: rdata = {vhi_q, lo_q};
            default:  rdata = {nm_q, hold};
        endcase
    end

    assign vec_hi      = vhi_q[3:0];
    assign edge_rise   = lo_q[CB_RISE];
    assign tl_from_pin = lo_q[CB_TLPIN];
    assign a0_from_pin = lo_q[CB_A0PIN];
    assign wait_en     = lo_q[CB_WAIT];
    assign nm_flag     = nm_q;
endmodule

// File: rtl/nlc_toplevel_path.sv
// Module: nlc_toplevel_path
// Synchronises the non-maskable pin, detects the chosen edge, selects the
// top-level source, keeps the pending flag and gates the request.
// Assumes wdog_eoc is already synchronous and one cycle wide.
module nlc_toplevel_path #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_pin,
    input  logic wdog_eoc,
    input  logic edge_rise,
    input  logic tl_from_pin,
    input  logic tl_ack,
    input  logic nm_flag,
    input  logic int_en,
    input  logic tl_mask,
    output logic tl_event,
    output logic tl_pending,
    output logic tl_req
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   pend_q;
    logic                   rise_det;
    logic                   fall_det;
    logic                   pin_evt;

    // synchroniser chain for the asynchronous pin
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= nmi_pin;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], nmi_pin};
            end
        end
    endgenerate

    // previous synchronised level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    // edge detection and source selection
    always_comb begin
        rise_det = sync_q[SYNC_STAGES-1] & ~prev_q;
        fall_det = ~sync_q[SYNC_STAGES-1] & prev_q;
        pin_evt  = edge_rise ? rise_det : fall_det;
        tl_event = tl_from_pin ? pin_evt : wdog_eoc;
    end

    // pending flag: event has priority over acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)        pend_q <= 1'b0;
        else if (tl_event) pend_q <= 1'b1;
        else if (tl_ack)   pend_q <= 1'b0;
    end

    // request gating by the sticky flag and the enables
    always_comb begin
        tl_pending = pend_q;
        tl_req     = nm_flag ? pend_q : (pend_q & int_en & tl_mask);
    end
endmodule

// File: rtl/nlc_hold_tracker.sv
// Module: nlc_hold_tracker
// Tracks preempted priority levels in nested mode and reports the level that
// the next interrupt return resumes (lowest set bit = highest priority).
// Assumes levels above LEVELS-1 are never preempted into the set.
module nlc_hold_tracker
    import nlc_pkg::*;
#(
    parameter int LVS = LEVELS,
    parameter int LW  = LVL_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           nested_mode,
    input  logic           preempt_vld,
    input  logic [LW-1:0]  cur_level,
    input  logic [LW-1:0]  new_level,
    input  logic           new_top,
    input  logic           iret,
    output logic [LVS-1:0] hold,
    output logic           resume_vld,
    output logic [LW-1:0]  resume_level
);
    logic [LVS-1:0] hold_q;
    logic [LVS-1:0] set_mask;
    logic [LVS-1:0] clr_mask;
    logic           qualify;

    // decide whether this preemption marks the running level
    always_comb begin
        qualify  = nested_mode && preempt_vld && !new_top &&
                   (new_level < cur_level) && (32'(cur_level) < LVS);
        set_mask = '0;
        for (int i = 0; i < LVS; i++) begin
            if (qualify && 32'(cur_level) == i) set_mask[i] = 1'b1;
        end
    end

    // find the lowest-numbered held level
    always_comb begin
        resume_level = '0;
        clr_mask     = '0;
        for (int i = LVS - 1; i >= 0; i--) begin
            if (hold_q[i]) begin
                resume_level = LW'(i);
                clr_mask     = '0;
                clr_mask[i]  = 1'b1;
            end
        end
    end

    // update the set: clear on return using the old set, then add new mark
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= (hold_q & ~(iret ? clr_mask : '0)) | set_mask;
        end
    end

    assign hold       = hold_q;
    assign resume_vld = |hold_q;
endmodule

// File: rtl/nested_level_ctrl.sv
// Module: nested_level_ctrl (top)
// Ties together the register file, the top-level request path, the A0 source
// routing and the hold-level tracker.
// Assumes all inputs except nmi_pin are synchronous to clk.
module nested_level_ctrl
    import nlc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              nmi_pin,
    input  logic              wdog_eoc,
    input  logic              ext_int_pin,
    input  logic              int_en,
    input  logic              tl_mask,
    input  logic              tl_ack,
    output logic              tl_req,
    output logic              tl_pending,
    output logic              inta0_src,
    output logic [3:0]        vec_hi,
    output logic              ext_wait_en,
    input  logic              nested_mode,
    input  logic              preempt_vld,
    input  logic [LVL_W-1:0]  cur_level,
    input  logic [LVL_W-1:0]  new_level,
    input  logic              new_top,
    input  logic              iret,
    output logic [LEVELS-1:0] hold_levels,
    output logic              resume_vld,
    output logic [LVL_W-1:0]  resume_level
);
    logic edge_rise;
    logic tl_from_pin;
    logic a0_from_pin;
    logic nm_flag;
    logic tl_event;

    nlc_ctrl_regs #(.W(DATA_W), .LVS(LEVELS)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .hold        (hold_levels),
        .rdata       (reg_rdata),
        .vec_hi      (vec_hi),
        .edge_rise   (edge_rise),
        .tl_from_pin (tl_from_pin),
        .a0_from_pin (a0_from_pin),
        .wait_en     (ext_wait_en),
        .nm_flag     (nm_flag)
    );

    nlc_toplevel_path #(.SYNC_STAGES(SYNC_STAGES)) u_tl (
        .clk         (clk),
        .rst_n       (rst_n),
        .nmi_pin     (nmi_pin),
        .wdog_eoc    (wdog_eoc),
        .edge_rise   (edge_rise),
        .tl_from_pin (tl_from_pin),
        .tl_ack      (tl_ack),
        .nm_flag     (nm_flag),
        .int_en      (int_en),
        .tl_mask     (tl_mask),
        .tl_event    (tl_event),
        .tl_pending  (tl_pending),
        .tl_req      (tl_req)
    );

    // A0 routing: the watchdog goes to A0 only when the top level does not own it
    always_comb begin
        if (tl_from_pin && !a0_from_pin) inta0_src = wdog_eoc;
        else                             inta0_src = ext_int_pin;
    end

    nlc_hold_tracker #(.LVS(LEVELS), .LW(LVL_W)) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .nested_mode  (nested_mode),
        .preempt_vld  (preempt_vld),
        .cur_level    (cur_level),
        .new_level    (new_level),
        .new_top      (new_top),
        .iret         (iret),
        .hold         (hold_levels),
        .resume_vld   (resume_vld),
        .resume_level (resume_level)
    );
endmodule

// File: rtl/nlc_checker.sv
// Module: nlc_checker
// Temporal properties of the controller, bound into the top module.
module nlc_checker
    import nlc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              nm_flag,
    input logic              tl_event,
    input logic              tl_pending,
    input logic              tl_req,
    input logic              tl_ack,
    input logic              int_en,
    input logic              tl_mask,
    input logic              tl_from_pin,
    input logic              inta0_src,
    input logic              ext_int_pin,
    input logic              nested_mode,
    input logic              preempt_vld,
    input logic              iret,
    input logic [LEVELS-1:0] hold_levels
);
    // R5
    nm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nm_flag |=> nm_flag);

    // R7
    nm_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nm_flag && tl_pending) |-> tl_req);

    // R6
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nm_flag && !(int_en && tl_mask)) |-> !tl_req);

    // R8
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tl_ack && !tl_event) |=> !tl_pending);

    // R4
    a0_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tl_from_pin |-> (inta0_src == ext_int_pin));

    // R9
    no_stray_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nested_mode && preempt_vld) |=> ((hold_levels & ~$past(hold_levels)) == '0));

    // R10
    iret_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iret && !preempt_vld && hold_levels != '0) |=>
        ($countones(hold_levels) + 1 == $past($countones(hold_levels))));
endmodule

bind nested_level_ctrl nlc_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .nm_flag     (nm_flag),
    .tl_event    (tl_event),
    .tl_pending  (tl_pending),
    .tl_req      (tl_req),
    .tl_ack      (tl_ack),
    .int_en      (int_en),
    .tl_mask     (tl_mask),
    .tl_from_pin (tl_from_pin),
    .inta0_src   (inta0_src),
    .ext_int_pin (ext_int_pin),
    .nested_mode (nested_mode),
    .preempt_vld (preempt_vld),
    .iret        (iret),
    .hold_levels (hold_levels)
);

// File: tb/nested_level_ctrl_test.sv
// Scoreboard bench: driver tasks push expectations, a monitor compares them.
module nested_level_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       nmi_pin = 1'b0;
    logic       wdog_eoc = 1'b0;
    logic       ext_int_pin = 1'b0;
    logic       int_en = 1'b0;
    logic       tl_mask = 1'b0;
    logic       tl_ack = 1'b0;
    logic       tl_req;
    logic       tl_pending;
    logic       inta0_src;
    logic [3:0] vec_hi;
    logic       ext_wait_en;
    logic       nested_mode = 1'b0;
    logic       preempt_vld = 1'b0;
    logic [2:0] cur_level = '0;
    logic [2:0] new_level = '0;
    logic       new_top = 1'b0;
    logic       iret = 1'b0;
    logic [6:0] hold_levels;
    logic       resume_vld;
    logic [2:0] resume_level;

    nested_level_ctrl uut (.*);

    always #2 clk = ~clk; // 250 MHz

    typedef enum int {O_RDATA, O_REQ, O_PEND, O_A0, O_HOLD, O_RESUME, O_VEC} obs_e;
    typedef struct {
        obs_e       sel;
        logic [7:0] exp;
        logic [7:0] mask;
        string      tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    function automatic logic [7:0] observe(obs_e s);
        case (s)
            O_RDATA:  return reg_rdata;
            O_REQ:    return {7'd0, tl_req};
            O_PEND:   return {7'd0, tl_pending};
            O_A0:     return {7'd0, inta0_src};
            O_HOLD:   return {1'b0, hold_levels};
            O_RESUME: return {4'd0, resume_vld, resume_level};
            default:  return {3'd0, ext_wait_en, vec_hi};
        endcase
    endfunction

    // monitor: pops expectations and compares away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = q.pop_front();
                act = observe(it.sel) & it.mask;
                checks++;
                if (act !== (it.exp & it.mask)) begin
                    errors++;
                    $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp & it.mask);
                end
            end
        end
    end

    task automatic expect_val(obs_e s, logic [7:0] e, string tag, logic [7:0] m = 8'hFF);
        item_t it;
        it.sel = s; it.exp = e; it.mask = m; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(logic a, logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic a, logic [7:0] e, string tag, logic [7:0] m = 8'hFF);
        reg_addr = a;
        expect_val(O_RDATA, e, tag, m);
        step();
    endtask

    task automatic ack();
        tl_ack = 1'b1; step(); tl_ack = 1'b0;
    endtask

    task automatic preempt(logic nm, logic [2:0] cl, logic [2:0] nl, logic top);
        nested_mode = nm; preempt_vld = 1'b1; cur_level = cl; new_level = nl; new_top = top;
        step();
        preempt_vld = 1'b0; new_top = 1'b0;
    endtask

    // watchdog
    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        // R1 reset state
        rd(1'b1, 8'h00, "R1 nest reg");
        rd(1'b0, 8'h06, "R1 ctrl low nibble", 8'h0F);
        expect_val(O_PEND, 0, "R1 pending"); expect_val(O_REQ, 0, "R1 req");
        step();

        // R13 readback
        wr(1'b0, 8'hA7);
        rd(1'b0, 8'hA7, "R13 ctrl readback");
        expect_val(O_VEC, 8'h1A, "R13 vec/wait outputs");
        step();
        wr(1'b0, 8'hA6);

        // R2 falling edge selected: rising ignored
        nmi_pin = 1'b1; step(4);
        expect_val(O_PEND, 0, "R2 rising ignored"); step();
        nmi_pin = 1'b0; step(2);
        expect_val(O_PEND, 0, "R2 not yet after two edges"); step();
        expect_val(O_PEND, 1, "R2 falling sets at third edge"); step();
        ack();
        expect_val(O_PEND, 0, "R8 ack clears"); step();
        // rising edge selected
        wr(1'b0, 8'hAE);
        nmi_pin = 1'b1; step(3);
        expect_val(O_PEND, 1, "R2 rising sets"); step();
        // R6 gating while pending
        int_en = 1'b0; tl_mask = 1'b1; step();
        expect_val(O_REQ, 0, "R6 enable off"); step();
        int_en = 1'b1; tl_mask = 1'b0; step();
        expect_val(O_REQ, 0, "R6 mask off"); step();
        tl_mask = 1'b1; step();
        expect_val(O_REQ, 1, "R6 all set"); step();
        ack();
        nmi_pin = 1'b0; step(4);
        expect_val(O_PEND, 0, "R2 falling ignored when rising chosen"); step();

        // R3 watchdog source
        wr(1'b0, 8'hAA);
        nmi_pin = 1'b1; step(4); nmi_pin = 1'b0; step(4);
        expect_val(O_PEND, 0, "R3 pin ignored with watchdog source"); step();
        wdog_eoc = 1'b1; step(); wdog_eoc = 1'b0;
        expect_val(O_PEND, 1, "R3 watchdog sets"); step();
        // R8 set beats ack
        wdog_eoc = 1'b1; tl_ack = 1'b1; step(); wdog_eoc = 1'b0; tl_ack = 1'b0;
        expect_val(O_PEND, 1, "R8 event beats ack"); step();
        ack();
        expect_val(O_PEND, 0, "R8 ack alone clears"); step();
        wr(1'b0, 8'hAE);
        wdog_eoc = 1'b1; step(); wdog_eoc = 1'b0;
        expect_val(O_PEND, 0, "R3 watchdog ignored with pin source"); step();

        // R4 A0 routing
        ext_int_pin = 1'b1; step();
        expect_val(O_A0, 1, "R4 pin route"); step();
        wr(1'b0, 8'hAC);
        expect_val(O_A0, 0, "R4 watchdog route low"); step();
        wdog_eoc = 1'b1; ext_int_pin = 1'b0; #1;
        expect_val(O_A0, 1, "R4 watchdog route high"); step();
        wdog_eoc = 1'b0;
        wr(1'b0, 8'hA8);
        ext_int_pin = 1'b1; #1;
        expect_val(O_A0, 1, "R4 guard forces pin"); step();
        ext_int_pin = 1'b0;
        wr(1'b0, 8'hAE);

        // R5 / R7 sticky flag
        wr(1'b1, 8'h80);
        rd(1'b1, 8'h80, "R5 sticky set");
        wr(1'b1, 8'h00);
        rd(1'b1, 8'h80, "R5 zero write ignored");
        int_en = 1'b0; tl_mask = 1'b0;
        nmi_pin = 1'b1; step(3);
        expect_val(O_REQ, 1, "R7 request despite enables"); step();
        ack();
        expect_val(O_REQ, 0, "R7 follows pending"); step();

        // R9 hold setting
        preempt(1'b1, 3'd5, 3'd2, 1'b0);
        expect_val(O_HOLD, 8'h20, "R9 level5 held"); step();
        preempt(1'b1, 3'd2, 3'd0, 1'b0);
        expect_val(O_HOLD, 8'h24, "R9 level2 held"); step();
        preempt(1'b1, 3'd0, 3'd0, 1'b1);
        expect_val(O_HOLD, 8'h24, "R9 top-level ignored"); step();
        preempt(1'b1, 3'd3, 3'd4, 1'b0);
        expect_val(O_HOLD, 8'h24, "R9 lower priority ignored"); step();
        preempt(1'b0, 3'd6, 3'd1, 1'b0);
        expect_val(O_HOLD, 8'h24, "R9 non-nested ignored"); step();
        expect_val(O_RESUME, 8'h0A, "R10 resume level2"); step();
        // R11 software cannot touch hold bits
        wr(1'b1, 8'h7F);
        rd(1'b1, 8'hA4, "R11 hold readback unchanged");
        // R10 return
        iret = 1'b1; step(); iret = 1'b0;
        expect_val(O_HOLD, 8'h20, "R10 iret clears level2");
        expect_val(O_RESUME, 8'h0D, "R10 resume level5"); step();
        // R12 same-cycle iret and preemption
        nested_mode = 1'b1; preempt_vld = 1'b1; cur_level = 3'd3; new_level = 3'd1; iret = 1'b1;
        step();
        preempt_vld = 1'b0; iret = 1'b0;
        expect_val(O_HOLD, 8'h08, "R12 clear old, set new"); step();
        iret = 1'b1; step(); iret = 1'b0;
        expect_val(O_RESUME, 8'h00, "R10 empty after last return"); step();

        // R5 reset clears sticky flag
        rst_n = 1'b0; step(2); rst_n = 1'b1; step();
        rd(1'b1, 8'h00, "R5 reset clears sticky");
        step(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule